// File: doc/BRIEF.md
# Auto-Reload Timer PWM Generator

This block is a 32-bit up-counting timer that drives one pulse-width-modulated line. Software programs a reload value and a compare value. Each time the counter passes all-ones it wraps to the reload value, and that wrap flips the output. A compare hit also flips the output when compare is enabled. The reload value therefore fixes the period and the compare value fixes how long the line stays in its active phase. A control field selects the output's idle level and an optional power-of-two clock divider in front of the counter.

Configuration uses a small write port. The port accepts writes only while the timer is stopped. A start pulse begins counting and a stop pulse freezes the counter. The usual sequence is: stop, write reload, compare and control, preset the counter to one below all-ones, then start. The line then enters its active phase on the second counter advance.

Top module: `pwm_reload_timer`

## Requirements
- R1: After reset the timer is stopped, every register is zero and `pwm_o` is low.
- R2: `wr_sel_i` chooses the target of a write: 0 reload, 1 compare, 2 counter, 3 control. Control bit 0 enables compare, bit 1 inverts the output, bit 2 enables the divider and bits 5:3 give the divider exponent. Any write made while the timer runs is ignored.
- R3: On each advance the counter goes up by one. When it advances from all-ones it loads the reload value and the output flips (overflow event).
- R4: With reload L and compare M, where L <= M < all-ones, one period is (all-ones - L + 1) advances. The active phase lasts (M - L + 1) advances and the idle phase lasts (all-ones - M) advances.
- R5: With compare enabled, an advance taken while the counter equals the compare value flips the output. With compare disabled only overflow flips it. When an overflow and a compare hit fall on the same advance, the output flips once.
- R6: A start pulse while stopped makes the timer run from the next cycle. With the counter preset to all-ones minus one, the output turns active two cycles after the running state begins and not before.
- R7: Stop has priority over start. It freezes the counter and the phase state, and while stopped the output shows the idle level. A later start resumes the same phase from the frozen count.
- R8: Writing the counter returns the phase state to idle.
- R9: With invert clear the idle level is low and the active level is high. With invert set the idle level is high and the active level is low.
- R10: With the divider enabled and exponent E, the counter advances once every 2^(E+1) clocks. With the divider disabled it advances every clock. The divider restarts from zero at each start and at each stop.
- R11: With reload and compare both all-ones minus one, the output alternates every clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start counting (pulse) |
| stop_i | input | 1 | Stop counting (pulse), wins over start |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register select: 0 reload, 1 compare, 2 counter, 3 control |
| wr_data_i | input | 32 | Write data |
| pwm_o | output | 1 | PWM output |

## Verification
A behavioural reference model runs beside the design and its output is compared on every clock. The basic duty setting is then measured phase by phase in cycles, which separates the active-length and idle-length formulas and the two-cycle start latency. Further patterns cover: a reload write while running, which must leave the period at its old length; a stop in mid-phase followed by a restart, which tells freezing apart from clearing; an inverted output; compare disabled against compare placed on all-ones, which both give a square wave at the overflow rate; a divide-by-four run that scales both phases; and the minimum two-cycle period.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;

    localparam int DIV_EXP_W = 3;

    typedef enum logic [1:0] {
        SEL_RELOAD  = 2'd0,
        SEL_COMPARE = 2'd1,
        SEL_COUNT   = 2'd2,
        SEL_CTRL    = 2'd3
    } reg_sel_e;

    // control word, bit 0 at the bottom
    typedef struct packed {
        logic [DIV_EXP_W-1:0] div_exp;
        logic                 div_en;
        logic                 invert;
        logic                 cmp_en;
    } ctrl_t;

endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
    parameter int EXP_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go_i,
    input  logic             clr_i,
    input  logic             div_en_i,
    input  logic [EXP_W-1:0] div_exp_i,
    output logic             tick_o
);
    localparam int DIV_W = 1 << EXP_W;

    logic [DIV_W-1:0] psc_d, psc_q;
    logic [EXP_W:0]   shift;
    logic [DIV_W-1:0] limit;

    always_comb begin
        shift  = {1'b0, div_exp_i} + (EXP_W+1)'(1);
        limit  = ~({DIV_W{1'b1}} << shift);
        psc_d  = psc_q;
        tick_o = 1'b0;
        if (clr_i) begin
            psc_d = '0;
        end else if (go_i) begin
            if (!div_en_i) begin
                tick_o = 1'b1;
            end else if (psc_q == limit) begin
                tick_o = 1'b1;
                psc_d  = '0;
            end else begin
                psc_d = psc_q + DIV_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) psc_q <= '0;
        else        psc_q <= psc_d;
    end

    // R10: a divided tick is never followed directly by another one
    p_div_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (div_en_i && tick_o) |=> !tick_o);

endmodule

// File: rtl/pwm_counter.sv
module pwm_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             wr_i,
    input  logic [CNT_W-1:0] wr_val_i,
    input  logic [CNT_W-1:0] reload_i,
    input  logic [CNT_W-1:0] compare_i,
    input  logic             cmp_en_i,
    output logic             flip_o
);
    localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic             at_top, at_cmp;

    always_comb begin
        at_top = (cnt_q == TOP);
        at_cmp = cmp_en_i && (cnt_q == compare_i);
        flip_o = tick_i && (at_top || at_cmp);
        cnt_d  = cnt_q;
        if (wr_i) begin
            cnt_d = wr_val_i;
        end else if (tick_i) begin
            cnt_d = at_top ? reload_i : cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R7: without a tick or a write the count stays frozen
    p_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !wr_i) |=> $stable(cnt_q));
    // R3: a tick at all-ones wraps to the reload value
    p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && cnt_q == TOP) |=> (cnt_q == $past(reload_i)));
    // R3: any other tick counts up by one
    p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && cnt_q != TOP) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

endmodule

// File: rtl/pwm_phase.sv
module pwm_phase (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic flip_i,
    input  logic run_i,
    input  logic invert_i,
    output logic pwm_o
);
    logic tgl_d, tgl_q;

    always_comb begin
        tgl_d = tgl_q;
        if (clr_i)       tgl_d = 1'b0;
        else if (flip_i) tgl_d = ~tgl_q;
        pwm_o = run_i ? (tgl_q ^ invert_i) : invert_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tgl_q <= 1'b0;
        else        tgl_q <= tgl_d;
    end

    // R8: a counter write leaves the phase idle
    p_phase_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !tgl_q);
    // R5: the phase moves only on an event
    p_phase_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !flip_i) |=> $stable(tgl_q));

endmodule

// File: rtl/pwm_reload_timer.sv
module pwm_reload_timer
    import pwm_timer_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic             wr_en_i,
    input  logic [1:0]       wr_sel_i,
    input  logic [CNT_W-1:0] wr_data_i,
    output logic             pwm_o
);
    localparam int CTRL_W = $bits(ctrl_t);

    typedef struct packed {
        logic             run;
        logic [CNT_W-1:0] reload;
        logic [CNT_W-1:0] compare;
        ctrl_t            ctrl;
    } regs_t;

    regs_t    regs_d, regs_q;
    reg_sel_e sel;
    logic     wr_ok, cnt_wr, go, div_clr, tick, flip;

    always_comb begin
        sel     = reg_sel_e'(wr_sel_i);
        wr_ok   = wr_en_i && !regs_q.run;
        cnt_wr  = wr_ok && (sel == SEL_COUNT);
        go      = regs_q.run && !stop_i;
        div_clr = stop_i || (start_i && !regs_q.run);
        regs_d  = regs_q;
        if (wr_ok) begin
            case (sel)
                SEL_RELOAD:  regs_d.reload  = wr_data_i;
                SEL_COMPARE: regs_d.compare = wr_data_i;
                SEL_CTRL:    regs_d.ctrl    = ctrl_t'(wr_data_i[CTRL_W-1:0]);
                default:     ;
            endcase
        end
        if (stop_i)       regs_d.run = 1'b0;
        else if (start_i) regs_d.run = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    pwm_prescaler #(.EXP_W(DIV_EXP_W)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .go_i      (go),
        .clr_i     (div_clr),
        .div_en_i  (regs_q.ctrl.div_en),
        .div_exp_i (regs_q.ctrl.div_exp),
        .tick_o    (tick)
    );

    pwm_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick),
        .wr_i      (cnt_wr),
        .wr_val_i  (wr_data_i),
        .reload_i  (regs_q.reload),
        .compare_i (regs_q.compare),
        .cmp_en_i  (regs_q.ctrl.cmp_en),
        .flip_o    (flip)
    );

    pwm_phase u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (cnt_wr),
        .flip_i   (flip),
        .run_i    (regs_q.run),
        .invert_i (regs_q.ctrl.invert),
        .pwm_o    (pwm_o)
    );

    // R2: configuration is locked while running
    p_cfg_locked_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.run && wr_en_i) |=> ($stable(regs_q.reload) && $stable(regs_q.compare)
                                     && $stable(regs_q.ctrl)));
    // R7: stop always wins
    p_stop_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> !regs_q.run);
    // R7: no advance without the running state
    p_no_tick_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !regs_q.run |-> !tick);

endmodule

// File: tb/pwm_reload_timer_test.sv
module pwm_reload_timer_test;
    localparam logic [31:0] ONES = 32'hFFFF_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0, stop_i = 1'b0, wr_en_i = 1'b0;
    logic [1:0]  wr_sel_i = 2'd0;
    logic [31:0] wr_data_i = '0;
    logic        pwm_o;

    int total = 0, bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    pwm_reload_timer uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
        .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i), .pwm_o(pwm_o)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // reference model, advanced at every rising edge
    bit        m_run, m_tog;
    int        m_psc;
    bit [31:0] m_cnt, m_rel, m_cmp;
    bit [5:0]  m_ctrl;
    always @(posedge clk) begin
        bit w, tk, ov, mt;
        if (!rst_n) begin
            m_run = 0; m_tog = 0; m_psc = 0; m_cnt = 0; m_rel = 0; m_cmp = 0; m_ctrl = 0;
        end else begin
            w = wr_en_i && !m_run;
            if (stop_i) begin
                m_run = 0; m_psc = 0;
            end else if (start_i && !m_run) begin
                m_run = 1; m_psc = 0;
            end else if (m_run) begin
                tk = 0;
                if (m_ctrl[2]) begin
                    if (m_psc == (1 << (int'(m_ctrl[5:3]) + 1)) - 1) begin
                        tk = 1; m_psc = 0;
                    end else m_psc++;
                end else tk = 1;
                if (tk) begin
                    ov = (m_cnt == ONES);
                    mt = m_ctrl[0] && (m_cnt == m_cmp);
                    if (ov || mt) m_tog = !m_tog;
                    m_cnt = ov ? m_rel : m_cnt + 1;
                end
            end
            if (w) begin
                case (wr_sel_i)
                    2'd0: m_rel = wr_data_i;
                    2'd1: m_cmp = wr_data_i;
                    2'd2: begin m_cnt = wr_data_i; m_tog = 0; end
                    default: m_ctrl = wr_data_i[5:0];
                endcase
            end
        end
    end

    // per-cycle comparison (R3 and R4 traced through the model)
    always @(negedge clk) begin
        bit m_out;
        if (rst_n && !finished) begin
            m_out = m_run ? (m_tog ^ m_ctrl[1]) : m_ctrl[1];
            chk(pwm_o === m_out, "R3 R4 model trace", pwm_o, m_out);
        end
    end

    task automatic wr(input logic [1:0] s, input logic [31:0] d);
        wr_en_i = 1; wr_sel_i = s; wr_data_i = d;
        @(negedge clk);
        wr_en_i = 0;
    endtask

    task automatic pulse_start();
        start_i = 1; @(negedge clk); start_i = 0;
    endtask

    task automatic pulse_stop();
        stop_i = 1; @(negedge clk); stop_i = 0;
    endtask

    // length of the current level, returns at the first sample of the other level
    task automatic run_len(output int n);
        logic lv;
        lv = pwm_o; n = 1;
        forever begin
            @(negedge clk);
            if (pwm_o === lv) n++; else break;
        end
    endtask

    task automatic setup(input logic [31:0] rel, input logic [31:0] cmp, input logic [31:0] ctl);
        pulse_stop();
        wr(2'd0, rel); wr(2'd1, cmp); wr(2'd3, ctl); wr(2'd2, ONES - 1);
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        int a, b, x;
        repeat (3) @(negedge clk);
        rst_n = 1;
        chk(pwm_o === 1'b0, "R1 reset level", pwm_o, 0);

        // basic duty: period 10, active 4
        setup(ONES - 9, ONES - 6, 32'd1);
        pulse_start();
        chk(pwm_o === 1'b0, "R6 idle right after start", pwm_o, 0);
        @(negedge clk);
        chk(pwm_o === 1'b0, "R6 idle one cycle later", pwm_o, 0);
        @(negedge clk);
        chk(pwm_o === 1'b1, "R6 active on second advance", pwm_o, 1);
        run_len(a); chk(a == 4, "R4 active length", a, 4);
        run_len(b); chk(b == 6, "R4 idle length", b, 6);

        // reload write while running must be ignored
        wr(2'd0, ONES - 2);
        run_len(x); run_len(a); run_len(b);
        chk(a + b == 10, "R2 write while running ignored", a + b, 10);

        // freeze at the start of the active phase, then resume
        while (pwm_o !== 1'b1) @(negedge clk);
        pulse_stop();
        repeat (4) @(negedge clk);
        chk(pwm_o === 1'b0, "R7 idle level while stopped", pwm_o, 0);
        pulse_start();
        run_len(a); chk(a == 4, "R7 phase resumes from frozen count", a, 4);

        // inverted output
        setup(ONES - 9, ONES - 6, 32'd3);
        chk(pwm_o === 1'b1, "R9 inverted idle high", pwm_o, 1);
        pulse_start(); @(negedge clk); @(negedge clk);
        chk(pwm_o === 1'b0, "R9 inverted active low", pwm_o, 0);
        run_len(a); chk(a == 4, "R9 inverted active length", a, 4);

        // compare disabled: toggles only on overflow
        setup(ONES - 9, ONES - 6, 32'd0);
        pulse_start(); @(negedge clk); @(negedge clk);
        run_len(a); chk(a == 10, "R5 compare off high", a, 10);
        run_len(b); chk(b == 10, "R5 compare off low", b, 10);

        // compare on all-ones coincides with overflow: single flip
        setup(ONES - 4, ONES, 32'd1);
        pulse_start(); @(negedge clk); @(negedge clk);
        run_len(a); chk(a == 5, "R5 coincident events high", a, 5);
        run_len(b); chk(b == 5, "R5 coincident events low", b, 5);

        // divide by four
        setup(ONES - 9, ONES - 6, 32'd13);
        pulse_start();
        repeat (7) @(negedge clk);
        chk(pwm_o === 1'b0, "R10 still idle before second divided tick", pwm_o, 0);
        @(negedge clk);
        chk(pwm_o === 1'b1, "R10 active after second divided tick", pwm_o, 1);
        run_len(a); chk(a == 16, "R10 divided active length", a, 16);
        run_len(b); chk(b == 24, "R10 divided idle length", b, 24);

        // counter write clears phase: active-low check after reconfig
        pulse_stop();
        wr(2'd2, ONES - 1);
        pulse_start();
        chk(pwm_o === 1'b0, "R8 phase idle after counter write", pwm_o, 0);

        // minimum period
        setup(ONES - 1, ONES - 1, 32'd1);
        pulse_start(); @(negedge clk); @(negedge clk);
        run_len(x); run_len(a); run_len(b);
        chk(a == 1 && b == 1, "R11 minimum period alternates", a * 10 + b, 11);

        pulse_stop();
        repeat (3) @(negedge clk);
        finished = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog expired actual=0 expected=1");
            summary();
            $finish;
        end
    end

endmodule